// File: doc/BRIEF.md
# Remote Terminal Command Address Decoder

This block sits behind the serial receiver of a remote terminal on a command/response bus. It receives each 16-bit command word as a one-cycle strobe. It decides whether the terminal must answer the command, either because the command carries the terminal's own strapped address or because it is a broadcast. It classifies the command as a mode command or a data transfer, and it holds the command's fields for the subsystem while the command is serviced.

The strapped terminal address arrives on five pins plus a parity pin. If the parity check fails, the block reports it on an active-low error output and stops answering commands addressed to a single terminal. Broadcast commands are still answered when broadcast is enabled. The low address outputs are shared between two sources. They show the latched word-count or mode-code field when no command is in service or the command is a mode command. Otherwise they show a running word counter, which the subsystem advances once per transferred word.

Top module: `cmd_addr_decoder`

## Requirements
- R1: A command word with `cmd_valid_i` high is accepted when its address field (bits 15:11) equals `strap_addr_i` and the strap parity is good. `respond_o` is high for exactly the one cycle after the strobe and low at all other times.
- R2: `addr_par_err_no` is low exactly when the count of ones over `strap_addr_i` and `strap_par_i` together is even. Odd parity is good. The output follows the inputs without a clock.
- R3: While `addr_par_err_no` is low, a command whose address is not a broadcast is never accepted, even when it equals the strapped address.
- R4: A command with address 31 (all ones) while `bcast_en_i` is high is accepted as a broadcast, with or without a parity error. `bcast_o` is then high together with `respond_o`.
- R5: While `bcast_en_i` is low, address 31 is accepted only if it equals a strapped address with good parity. `bcast_o` is then low.
- R6: `mode_cmd_o` is latched on acceptance. It is high when the subaddress field (bits 9:5) is 0 or 31, and low otherwise.
- R7: `in_cmd_o` rises in the cycle after an accepted command. It falls in the cycle after `msg_done_i` is high with no accepted command on the same edge. An accepted command takes priority over `msg_done_i`.
- R8: On acceptance, `tr_o` latches bit 10 and `subaddr_o` latches bits 9:5. A command that is not accepted leaves every latched output, `in_cmd_o`, and the word counter unchanged.
- R9: `wc_addr_o` shows the latched field from bits 4:0 when `in_cmd_o` is low or `mode_cmd_o` is high.
- R10: When `in_cmd_o` is high and `mode_cmd_o` is low, `wc_addr_o` shows the word counter. The counter clears to 0 on acceptance. It adds 1 on each edge where `word_adv_i` is high, `in_cmd_o` is high and no command is accepted. It wraps from 31 to 0.
- R11: While `rst_ni` is low, `respond_o`, `bcast_o`, `mode_cmd_o`, `in_cmd_o`, `tr_o`, `subaddr_o` and `wc_addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | One-cycle strobe: a command word is present |
| cmd_word_i | input | 16 | Received command word |
| strap_addr_i | input | 5 | Strapped terminal address |
| strap_par_i | input | 1 | Parity pin for the strapped address |
| bcast_en_i | input | 1 | Enables recognition of address 31 as broadcast |
| word_adv_i | input | 1 | Advance the word counter by one |
| msg_done_i | input | 1 | End of command service |
| respond_o | output | 1 | One-cycle pulse: command accepted |
| bcast_o | output | 1 | Latched: accepted command was a broadcast |
| mode_cmd_o | output | 1 | Latched: accepted command is a mode command |
| addr_par_err_no | output | 1 | Active-low strap parity error |
| in_cmd_o | output | 1 | A command is in service |
| tr_o | output | 1 | Latched transmit/receive bit |
| subaddr_o | output | 5 | Latched subaddress |
| wc_addr_o | output | 5 | Word-count field or running word counter |

## Verification
The bench builds the block with its default parameters: 5-bit address, subaddress and count fields, and odd strap parity. These widths make all 32 addresses and all 32 subaddresses reachable, including the broadcast address 31 and both mode-command values. Runs of up to 40 word advances carry the 5-bit counter past its wrap from 31 to 0. The strap pattern changes during the run, covering good parity, bad parity and a strapped address of 31 with broadcast enable both high and low.

// File: rtl/cad_pkg.sv
package cad_pkg;
   typedef enum logic {
      PAR_ODD  = 1'b0,
      PAR_EVEN = 1'b1
   } par_kind_e;

   typedef enum logic {
      SRC_FIELD = 1'b0,
      SRC_COUNT = 1'b1
   } wc_src_e;
endpackage

// File: rtl/cad_parity_chk.sv
module cad_parity_chk
   import cad_pkg::*;
#(
   parameter int unsigned W    = 5,
   parameter par_kind_e   KIND = PAR_ODD
) (
   input  logic [W-1:0] addr_i,
   input  logic         par_i,
   output logic         ok_o
);
   if (W < 1) begin : g_bad_w
      $error("cad_parity_chk: W must be at least 1");
   end

   logic ones_odd;
   assign ones_odd = ^{par_i, addr_i};

   if (KIND == PAR_ODD) begin : g_odd
      assign ok_o = ones_odd;
   end else begin : g_even
      assign ok_o = ~ones_odd;
   end
endmodule

// File: rtl/cad_field_decode.sv
module cad_field_decode #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned SA_W   = 5,
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned WORD_W = ADDR_W + 1 + SA_W + CNT_W
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [ADDR_W-1:0] strap_i,
   input  logic              strap_ok_i,
   input  logic              bcast_en_i,
   output logic              own_hit_o,
   output logic              bcast_hit_o,
   output logic              mode_hit_o,
   output logic              tr_o,
   output logic [SA_W-1:0]   sa_o,
   output logic [CNT_W-1:0]  wc_o
);
   localparam int unsigned TR_POS = CNT_W + SA_W;
   localparam int unsigned AD_LSB = TR_POS + 1;

   if (WORD_W != ADDR_W + 1 + SA_W + CNT_W) begin : g_bad_word
      $error("cad_field_decode: WORD_W does not match the field widths");
   end

   logic [ADDR_W-1:0] addr;
   logic [ADDR_W-1:0] diff;

   assign addr = word_i[AD_LSB +: ADDR_W];
   assign tr_o = word_i[TR_POS];
   assign sa_o = word_i[CNT_W +: SA_W];
   assign wc_o = word_i[0 +: CNT_W];

   for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
      assign diff[i] = addr[i] ^ strap_i[i];
   end

   logic addr_all_ones;
   logic sa_all_ones;
   logic sa_all_zero;

   assign addr_all_ones = &addr;
   assign sa_all_ones   = &sa_o;
   assign sa_all_zero   = ~|sa_o;

   assign bcast_hit_o = bcast_en_i & addr_all_ones;
   assign own_hit_o   = strap_ok_i & ~|diff & ~bcast_hit_o;
   assign mode_hit_o  = sa_all_ones | sa_all_zero;
endmodule

// File: rtl/cad_word_ctr.sv
module cad_word_ctr #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             adv_i,
   output logic [CNT_W-1:0] cnt_o
);
   if (CNT_W < 1) begin : g_bad_w
      $error("cad_word_ctr: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/cad_addr_mux.sv
module cad_addr_mux
   import cad_pkg::*;
#(
   parameter int unsigned W = 5
) (
   input  wc_src_e      sel_i,
   input  logic [W-1:0] field_i,
   input  logic [W-1:0] count_i,
   output logic [W-1:0] addr_o
);
   always_comb begin
      unique case (sel_i)
         SRC_COUNT: addr_o = count_i;
         default:   addr_o = field_i;
      endcase
   end
endmodule

// File: rtl/cmd_addr_decoder.sv
module cmd_addr_decoder
   import cad_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned SA_W     = 5,
   parameter int unsigned CNT_W    = 5,
   parameter par_kind_e   PAR_KIND = PAR_ODD,
   parameter int unsigned WORD_W   = ADDR_W + 1 + SA_W + CNT_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_valid_i,
   input  logic [WORD_W-1:0] cmd_word_i,
   input  logic [ADDR_W-1:0] strap_addr_i,
   input  logic              strap_par_i,
   input  logic              bcast_en_i,
   input  logic              word_adv_i,
   input  logic              msg_done_i,
   output logic              respond_o,
   output logic              bcast_o,
   output logic              mode_cmd_o,
   output logic              addr_par_err_no,
   output logic              in_cmd_o,
   output logic              tr_o,
   output logic [SA_W-1:0]   subaddr_o,
   output logic [CNT_W-1:0]  wc_addr_o
);
   if (ADDR_W < 1 || SA_W < 1 || CNT_W < 1) begin : g_bad_w
      $error("cmd_addr_decoder: every field needs at least one bit");
   end
   if (WORD_W != ADDR_W + 1 + SA_W + CNT_W) begin : g_bad_word
      $error("cmd_addr_decoder: WORD_W must equal the sum of the fields");
   end

   logic strap_ok;

   cad_parity_chk #(
      .W    (ADDR_W),
      .KIND (PAR_KIND)
   ) u_par (
      .addr_i (strap_addr_i),
      .par_i  (strap_par_i),
      .ok_o   (strap_ok)
   );

   assign addr_par_err_no = strap_ok;

   logic             own_hit;
   logic             bcast_hit;
   logic             mode_hit;
   logic             f_tr;
   logic [SA_W-1:0]  f_sa;
   logic [CNT_W-1:0] f_wc;

   cad_field_decode #(
      .ADDR_W (ADDR_W),
      .SA_W   (SA_W),
      .CNT_W  (CNT_W),
      .WORD_W (WORD_W)
   ) u_dec (
      .word_i      (cmd_word_i),
      .strap_i     (strap_addr_i),
      .strap_ok_i  (strap_ok),
      .bcast_en_i  (bcast_en_i),
      .own_hit_o   (own_hit),
      .bcast_hit_o (bcast_hit),
      .mode_hit_o  (mode_hit),
      .tr_o        (f_tr),
      .sa_o        (f_sa),
      .wc_o        (f_wc)
   );

   logic accept;
   assign accept = cmd_valid_i & (own_hit | bcast_hit);

   logic             resp_q;
   logic             bcast_q;
   logic             mode_q;
   logic             in_cmd_q;
   logic             tr_q;
   logic [SA_W-1:0]  sa_q;
   logic [CNT_W-1:0] wc_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         resp_q   <= 1'b0;
         bcast_q  <= 1'b0;
         mode_q   <= 1'b0;
         in_cmd_q <= 1'b0;
         tr_q     <= 1'b0;
         sa_q     <= '0;
         wc_q     <= '0;
      end else begin
         resp_q <= accept;
         if (accept) begin
            bcast_q  <= bcast_hit;
            mode_q   <= mode_hit;
            in_cmd_q <= 1'b1;
            tr_q     <= f_tr;
            sa_q     <= f_sa;
            wc_q     <= f_wc;
         end else if (msg_done_i) begin
            in_cmd_q <= 1'b0;
         end
      end
   end

   logic [CNT_W-1:0] cnt;

   cad_word_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (accept),
      .adv_i   (word_adv_i & in_cmd_q),
      .cnt_o   (cnt)
   );

   wc_src_e wc_sel;
   assign wc_sel = (!in_cmd_q || mode_q) ? SRC_FIELD : SRC_COUNT;

   cad_addr_mux #(
      .W (CNT_W)
   ) u_mux (
      .sel_i   (wc_sel),
      .field_i (wc_q),
      .count_i (cnt),
      .addr_o  (wc_addr_o)
   );

   assign respond_o  = resp_q;
   assign bcast_o    = bcast_q;
   assign mode_cmd_o = mode_q;
   assign in_cmd_o   = in_cmd_q;
   assign tr_o       = tr_q;
   assign subaddr_o  = sa_q;
endmodule

// File: rtl/cad_checker.sv
module cad_checker
   import cad_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned SA_W     = 5,
   parameter int unsigned CNT_W    = 5,
   parameter par_kind_e   PAR_KIND = PAR_ODD,
   parameter int unsigned WORD_W   = ADDR_W + 1 + SA_W + CNT_W
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cmd_valid_i,
   input logic [WORD_W-1:0] cmd_word_i,
   input logic [ADDR_W-1:0] strap_addr_i,
   input logic              strap_par_i,
   input logic              bcast_en_i,
   input logic              word_adv_i,
   input logic              msg_done_i,
   input logic              respond_o,
   input logic              bcast_o,
   input logic              mode_cmd_o,
   input logic              addr_par_err_no,
   input logic              in_cmd_o,
   input logic              tr_o,
   input logic [SA_W-1:0]   subaddr_o,
   input logic [CNT_W-1:0]  wc_addr_o
);
   localparam int unsigned TR_POS = CNT_W + SA_W;
   localparam int unsigned AD_LSB = TR_POS + 1;

   logic cmd_to_bcast;
   logic good_par;
   assign cmd_to_bcast = &cmd_word_i[AD_LSB +: ADDR_W];
   assign good_par = (PAR_KIND == PAR_ODD)
                     ? (($countones({strap_addr_i, strap_par_i}) % 2) == 1)
                     : (($countones({strap_addr_i, strap_par_i}) % 2) == 0);

   assert_parity_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_par_err_no == good_par);

   assert_own_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && !addr_par_err_no && !(bcast_en_i && cmd_to_bcast)) |=> !respond_o);

   assert_bcast_take_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && bcast_en_i && cmd_to_bcast) |=> (respond_o && bcast_o));

   assert_bcast_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && !bcast_en_i) |=> !(respond_o && bcast_o));

   assert_mode_class_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      respond_o |-> (mode_cmd_o == ((subaddr_o == '0) || (&subaddr_o))));

   assert_in_cmd_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      respond_o |-> in_cmd_o);

   assert_resp_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      respond_o |-> $past(cmd_valid_i));

   assert_tr_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      respond_o |-> (tr_o == $past(cmd_word_i[TR_POS])));

   assert_field_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_cmd_o && mode_cmd_o && !respond_o) |-> $stable(wc_addr_o));

   assert_count_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (respond_o && !mode_cmd_o) |-> (wc_addr_o == '0));
endmodule

bind cmd_addr_decoder cad_checker #(
   .ADDR_W   (ADDR_W),
   .SA_W     (SA_W),
   .CNT_W    (CNT_W),
   .PAR_KIND (PAR_KIND),
   .WORD_W   (WORD_W)
) u_chk (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .cmd_valid_i     (cmd_valid_i),
   .cmd_word_i      (cmd_word_i),
   .strap_addr_i    (strap_addr_i),
   .strap_par_i     (strap_par_i),
   .bcast_en_i      (bcast_en_i),
   .word_adv_i      (word_adv_i),
   .msg_done_i      (msg_done_i),
   .respond_o       (respond_o),
   .bcast_o         (bcast_o),
   .mode_cmd_o      (mode_cmd_o),
   .addr_par_err_no (addr_par_err_no),
   .in_cmd_o        (in_cmd_o),
   .tr_o            (tr_o),
   .subaddr_o       (subaddr_o),
   .wc_addr_o       (wc_addr_o)
);

// File: tb/cmd_addr_decoder_tb.sv
`timescale 1ns/1ps
module cmd_addr_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_word = '0;
   logic [4:0]  strap = 5'd1;
   logic        spar = 1'b0;
   logic        ben = 1'b0;
   logic        wadv = 1'b0;
   logic        mdone = 1'b0;
   logic        respond, bcast, mode, perr_n, in_cmd, tr;
   logic [4:0]  sa, wca;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cmd_addr_decoder u_dut (
      .clk_i (clk), .rst_ni (rst_n), .cmd_valid_i (cmd_valid), .cmd_word_i (cmd_word),
      .strap_addr_i (strap), .strap_par_i (spar), .bcast_en_i (ben),
      .word_adv_i (wadv), .msg_done_i (mdone), .respond_o (respond), .bcast_o (bcast),
      .mode_cmd_o (mode), .addr_par_err_no (perr_n), .in_cmd_o (in_cmd), .tr_o (tr),
      .subaddr_o (sa), .wc_addr_o (wca)
   );

   // behavioural reference
   int m_resp, m_bc, m_mode, m_in, m_tr, m_sa, m_wc, m_cnt;

   function automatic int par_good(input logic [4:0] a, input logic p);
      return ($countones({a, p}) % 2) == 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_resp = 0; m_bc = 0; m_mode = 0; m_in = 0; m_tr = 0; m_sa = 0; m_wc = 0; m_cnt = 0;
      end else begin
         int adr, is_bc, is_own, take;
         adr    = int'(cmd_word[15:11]);
         is_bc  = (ben && adr == 31) ? 1 : 0;
         is_own = (!is_bc && par_good(strap, spar) && adr == int'(strap)) ? 1 : 0;
         take   = (cmd_valid && (is_bc || is_own)) ? 1 : 0;
         if (take) begin
            m_resp = 1; m_bc = is_bc; m_in = 1;
            m_tr = int'(cmd_word[10]); m_sa = int'(cmd_word[9:5]); m_wc = int'(cmd_word[4:0]);
            m_mode = (m_sa == 0 || m_sa == 31) ? 1 : 0;
            m_cnt = 0;
         end else begin
            m_resp = 0;
            if (wadv && m_in) m_cnt = (m_cnt + 1) % 32;
            if (mdone) m_in = 0;
         end
      end
   end

   task automatic cmp(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         cmp("R1 respond", int'(respond), m_resp);
         cmp("R2 parity flag", int'(perr_n), par_good(strap, spar));
         cmp("R4/R5 bcast", int'(bcast), m_bc);
         cmp("R6 mode", int'(mode), m_mode);
         cmp("R7 in_cmd", int'(in_cmd), m_in);
         cmp("R8 tr", int'(tr), m_tr);
         cmp("R8 subaddr", int'(sa), m_sa);
         cmp("R9/R10 wc_addr", int'(wca), (m_in == 0 || m_mode == 1) ? m_wc : m_cnt);
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic send(input int adr, input int t, input int s, input int w);
      cmd_word = {adr[4:0], t[0], s[4:0], w[4:0]};
      cmd_valid = 1'b1;
      tick();
      cmd_valid = 1'b0;
   endtask

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      // R11 reset state
      tick(); tick();
      #1;
      cmp("R11 respond", int'(respond), 0); cmp("R11 in_cmd", int'(in_cmd), 0);
      cmp("R11 bcast", int'(bcast), 0);   cmp("R11 mode", int'(mode), 0);
      cmp("R11 tr", int'(tr), 0);         cmp("R11 subaddr", int'(sa), 0);
      cmp("R11 wc_addr", int'(wca), 0);
      rst_n = 1'b1;
      tick();
      // R1 own address, R10 count with wrap
      strap = 5'd3; spar = 1'b1; // 3 ones: good
      send(3, 1, 7, 4);
      cmp("R1 pulse", int'(respond), 1);
      wadv = 1'b1;
      repeat (34) tick();
      wadv = 1'b0;
      cmp("R10 wrap", int'(wca), 2);
      mdone = 1'b1; tick(); mdone = 1'b0;
      cmp("R9 idle field", int'(wca), 4);
      // R3 bad parity blocks own address
      spar = 1'b0;
      send(3, 0, 9, 1);
      cmp("R3 blocked", int'(respond), 0);
      cmp("R8 unchanged", int'(sa), 7);
      // R4 broadcast with bad parity
      ben = 1'b1;
      send(31, 0, 0, 17);
      cmp("R4 bcast", int'(bcast), 1);
      cmp("R6 mode zero sa", int'(mode), 1);
      wadv = 1'b1; repeat (3) tick(); wadv = 1'b0;
      cmp("R9 mode shows field", int'(wca), 17);
      // R5 strap 31, bcast disabled
      mdone = 1'b1; tick(); mdone = 1'b0;
      ben = 1'b0; strap = 5'd31; spar = 1'b0; // 5 ones: good
      send(31, 1, 31, 9);
      cmp("R5 own 31", int'(respond), 1);
      cmp("R5 not bcast", int'(bcast), 0);
      strap = 5'd30; spar = 1'b1;
      send(31, 0, 5, 2);
      cmp("R5 ignored", int'(respond), 0);
      // R7 accept beats done
      mdone = 1'b1; cmd_word = {5'd30, 1'b0, 5'd12, 5'd6}; cmd_valid = 1'b1;
      tick(); cmd_valid = 1'b0; mdone = 1'b0;
      cmp("R7 accept priority", int'(in_cmd), 1);
      // random traffic
      for (int cyc = 0; cyc < 6000; cyc++) begin
         int pick;
         if (cyc % 300 == 0) begin
            strap = 5'($urandom_range(0, 31)); spar = 1'($urandom_range(0, 1));
            ben = 1'($urandom_range(0, 1));
         end
         pick = $urandom_range(0, 2);
         cmd_word[15:11] = (pick == 0) ? strap : (pick == 1) ? 5'd31 : 5'($urandom_range(0, 31));
         pick = $urandom_range(0, 3);
         cmd_word[9:5] = (pick == 0) ? 5'd0 : (pick == 1) ? 5'd31 : 5'($urandom_range(0, 31));
         cmd_word[10] = 1'($urandom_range(0, 1));
         cmd_word[4:0] = 5'($urandom_range(0, 31));
         cmd_valid = ($urandom_range(0, 15) == 0);
         wadv = ($urandom_range(0, 1) == 1);
         mdone = ($urandom_range(0, 39) == 0);
         tick();
      end
      cmd_valid = 1'b0; wadv = 1'b0; mdone = 1'b0;
      tick();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      done = 1;
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule